// File: doc/BRIEF.md
# Modal LCD Controller Command Decoder

This block sits behind the host byte bus of a small graphic LCD controller. It interprets control bytes, which are bus writes with `is_data` low, and keeps the controller's configuration registers. These registers hold the column, page and start line, the contrast value, the line-reversal count, the indicator mode, display enable and oscillator run. It also tracks display-data accesses, which are bus writes or reads with `is_data` high, so that the column pointer advances.

Some commands are modal. Two of them open an exclusive state in which the next control byte is taken as a data operand and is never decoded as an opcode. A read-modify-write state changes how the column pointer reacts to reads. It also blocks explicit column moves and restores the column on exit. The reset pin initialises every register. A soft-reset opcode clears only the addressing and drive registers.

Top module: `lcdc_cmd_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following outputs are set. `col_addr`, `page_addr`, `start_line`, `nline_cnt`, `nline_on`, `ind_on`, `ind_mode`, `disp_on`, `osc_run` and `rmw_on` become 0. `contrast` becomes 6'b100000.
- R2: The bench relies on these plain opcodes. 0x0N sets column bits [3:0] to N. 0x1N sets column bits [7:4] to N. Bytes 0x40 to 0x7F set `start_line` to byte[5:0]. 0xBN sets `page_addr` to N. 0x9F sets `disp_on`, and 0x9E clears it.
- R3: Opcode 0x8C opens a contrast lock. The next control byte writes byte[5:0] to `contrast` and closes the lock. That byte is not decoded as a command, whatever its value.
- R4: Opcode 0x9D opens an indicator lock. The next control byte writes byte[1:0] to `ind_mode`, sets `ind_on` and closes the lock without being decoded. Opcode 0x9C clears `ind_on` and leaves `ind_mode` unchanged.
- R5: Outside read-modify-write mode, each display-data write or read raises `col_addr` by one. The column stops at COL_MAX, which is 131.
- R6: Opcode 0xC0 enters read-modify-write mode (`rmw_on`=1) and records the column. In this mode, reads leave the column unchanged, writes advance it, and 0x0N/0x1N are ignored while other commands still act. Opcode 0xC1 leaves the mode and restores the recorded column.
- R7: Opcode 0x3N sets `nline_cnt` to N and sets `nline_on`. Opcode 0xC4 clears `nline_on` and keeps `nline_cnt`.
- R8: Opcode 0x9B sets `osc_run` only when `cfg_master` and `cfg_int_osc` are both high. Otherwise it has no effect.
- R9: Opcode 0xC5 restores the R1 values of `col_addr`, `page_addr`, `start_line`, `contrast`, `nline_cnt`, `nline_on` and `rmw_on`. It leaves `disp_on`, `osc_run`, `ind_on` and `ind_mode` unchanged.
- R10: The no-operation byte 0xC3 and every control byte not listed in R2 to R9 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Byte write strobe, one cycle per byte |
| bus_rd | input | 1 | Display-data read strobe |
| is_data | input | 1 | 1: display data, 0: control byte |
| din | input | 8 | Written byte |
| cfg_master | input | 1 | Device strapped as master |
| cfg_int_osc | input | 1 | Internal oscillator selected |
| col_addr | output | 8 | Column pointer |
| page_addr | output | 4 | Page address |
| start_line | output | 6 | Display start line |
| contrast | output | 6 | Contrast register |
| nline_cnt | output | 4 | Line-reversal count |
| nline_on | output | 1 | Line reversal enabled |
| ind_on | output | 1 | Indicator enabled |
| ind_mode | output | 2 | Indicator mode |
| disp_on | output | 1 | Display enabled |
| osc_run | output | 1 | Oscillator running |
| rmw_on | output | 1 | Read-modify-write mode active |

## Verification
A single control byte can close an exclusive lock and also match a live opcode, so operand capture and opcode decoding compete for the same write. The bench provokes this by closing both locks with opcode-valued bytes such as 0x9F, 0xB5 and 0xC5. It judges the result at the ports: the operand field must load, and display, page and column must keep their earlier values. A second overlap occurs when leaving read-modify-write mode after writes have advanced the column. The restore must win, and the bench expects the recorded column rather than the advanced one.

// File: rtl/lcdc_pkg.sv
// Shared types for the LCD command decoder.
// Assumes 8-bit control bytes; opcode classes are listed in op_e.
package lcdc_pkg;
    typedef enum logic [3:0] {
        OP_NONE, OP_COL_LO, OP_COL_HI, OP_START, OP_PAGE, OP_DISP,
        OP_RMW_IN, OP_RMW_OUT, OP_SRST, OP_EC_MODE, OP_IND_ON,
        OP_IND_OFF, OP_NLINE, OP_NLINE_OFF, OP_OSC
    } op_e;

    typedef enum logic [1:0] {
        M_OPEN, M_EC_WAIT, M_IND_WAIT
    } mode_e;
endpackage

// File: rtl/lcdc_decode.sv
// Classifies a control byte into an opcode class.
// Purely combinational; unassigned bytes and the no-op byte map to OP_NONE.
module lcdc_decode
    import lcdc_pkg::*;
(
    input  logic [7:0] din,
    output op_e        op
);
    // Opcode classification by byte pattern
    always_comb begin
        casez (din)
            8'b0000_????: op = OP_COL_LO;
            8'b0001_????: op = OP_COL_HI;
            8'b0011_????: op = OP_NLINE;
            8'b01??_????: op = OP_START;
            8'b1011_????: op = OP_PAGE;
            8'h8C:        op = OP_EC_MODE;
            8'h9B:        op = OP_OSC;
            8'h9C:        op = OP_IND_OFF;
            8'h9D:        op = OP_IND_ON;
            8'h9E, 8'h9F: op = OP_DISP;
            8'hC0:        op = OP_RMW_IN;
            8'hC1:        op = OP_RMW_OUT;
            8'hC4:        op = OP_NLINE_OFF;
            8'hC5:        op = OP_SRST;
            default:      op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/lcdc_mode_fsm.sv
// Tracks the exclusive operand locks and the read-modify-write flag.
// Assumes at most one control write per cycle (ctl_wr is a single-cycle strobe).
module lcdc_mode_fsm
    import lcdc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  op_e  op,
    output logic cmd_ok,
    output logic ec_load,
    output logic ind_load,
    output logic rmw_on,
    output logic rmw_enter,
    output logic rmw_exit
);
    mode_e mode_q;

    assign cmd_ok    = ctl_wr && (mode_q == M_OPEN);
    assign ec_load   = ctl_wr && (mode_q == M_EC_WAIT);
    assign ind_load  = ctl_wr && (mode_q == M_IND_WAIT);
    assign rmw_enter = cmd_ok && (op == OP_RMW_IN) && !rmw_on;
    assign rmw_exit  = cmd_ok && (op == OP_RMW_OUT) && rmw_on;

    // Lock state: open, waiting for contrast operand, or waiting for indicator operand
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_OPEN;
        end else if (cmd_ok && op == OP_EC_MODE) begin
            mode_q <= M_EC_WAIT;
        end else if (cmd_ok && op == OP_IND_ON) begin
            mode_q <= M_IND_WAIT;
        end else if (ec_load || ind_load) begin
            mode_q <= M_OPEN;
        end
    end

    // Read-modify-write flag: set on entry, cleared on exit or soft reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rmw_on <= 1'b0;
        end else if (rmw_enter) begin
            rmw_on <= 1'b1;
        end else if (rmw_exit || (cmd_ok && op == OP_SRST)) begin
            rmw_on <= 1'b0;
        end
    end

    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != M_OPEN && !ctl_wr) |=> (mode_q == $past(mode_q)));
endmodule

// File: rtl/lcdc_col_ctr.sv
// Column pointer with saturating increment and read-modify-write save/restore.
// Assumes COL_W is between 5 and 8 so that the high nibble command fits.
module lcdc_col_ctr #(
    parameter int COL_W   = 8,
    parameter int COL_MAX = 131
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             set_lo,
    input  logic             set_hi,
    input  logic [3:0]       nib,
    input  logic             inc,
    input  logic             rmw_enter,
    input  logic             rmw_exit,
    output logic [COL_W-1:0] col
);
    localparam int               HI_W    = COL_W - 4;
    localparam logic [COL_W-1:0] COL_LIM = COL_W'(COL_MAX);

    logic [COL_W-1:0] col_q;
    logic [COL_W-1:0] save_q;

    assign col = col_q;

    // Column update: clear, restore, explicit set, then saturating increment
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            col_q <= '0;
        end else if (rmw_exit) begin
            col_q <= save_q;
        end else if (set_lo) begin
            col_q <= {col_q[COL_W-1:4], nib};
        end else if (set_hi) begin
            col_q <= {nib[HI_W-1:0], col_q[3:0]};
        end else if (inc && col_q < COL_LIM) begin
            col_q <= col_q + 1'b1;
        end
    end

    // Entry column capture for read-modify-write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_q <= '0;
        end else if (rmw_enter) begin
            save_q <= col_q;
        end
    end

    // R6
    rmw_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rmw_exit && !clr) |=> (col_q == $past(save_q)));

    // R5
    col_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !rmw_exit && !set_lo && !set_hi && col_q == COL_LIM) |=> (col_q == COL_LIM));
endmodule

// File: rtl/lcdc_cmd_top.sv
// Command decoder and configuration register file for a small graphic LCD controller.
// Assumes bus_wr and bus_rd are single-cycle strobes and are not raised together.
module lcdc_cmd_top
    import lcdc_pkg::*;
#(
    parameter int          COL_W   = 8,
    parameter int          COL_MAX = 131,
    parameter int          PAGE_W  = 4,
    parameter int          LINE_W  = 6,
    parameter int          EC_W    = 6,
    parameter int          NL_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              is_data,
    input  logic [7:0]        din,
    input  logic              cfg_master,
    input  logic              cfg_int_osc,
    output logic [COL_W-1:0]  col_addr,
    output logic [PAGE_W-1:0] page_addr,
    output logic [LINE_W-1:0] start_line,
    output logic [EC_W-1:0]   contrast,
    output logic [NL_W-1:0]   nline_cnt,
    output logic              nline_on,
    output logic              ind_on,
    output logic [1:0]        ind_mode,
    output logic              disp_on,
    output logic              osc_run,
    output logic              rmw_on
);
    localparam logic [EC_W-1:0] EC_RST = {1'b1, {(EC_W-1){1'b0}}};

    op_e  op;
    logic ctl_wr, cmd_ok, ec_load, ind_load, rmw_enter, rmw_exit;
    logic srst, col_inc;

    assign ctl_wr  = bus_wr && !is_data;
    assign srst    = cmd_ok && (op == OP_SRST);
    assign col_inc = (bus_wr && is_data) || (bus_rd && is_data && !rmw_on);

    lcdc_decode i_decode (
        .din (din),
        .op  (op)
    );

    lcdc_mode_fsm i_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .op        (op),
        .cmd_ok    (cmd_ok),
        .ec_load   (ec_load),
        .ind_load  (ind_load),
        .rmw_on    (rmw_on),
        .rmw_enter (rmw_enter),
        .rmw_exit  (rmw_exit)
    );

    lcdc_col_ctr #(
        .COL_W   (COL_W),
        .COL_MAX (COL_MAX)
    ) i_col (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (srst),
        .set_lo    (cmd_ok && op == OP_COL_LO && !rmw_on),
        .set_hi    (cmd_ok && op == OP_COL_HI && !rmw_on),
        .nib       (din[3:0]),
        .inc       (col_inc),
        .rmw_enter (rmw_enter),
        .rmw_exit  (rmw_exit),
        .col       (col_addr)
    );

    // Addressing registers: page and start line, cleared by soft reset
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            page_addr  <= '0;
            start_line <= '0;
        end else begin
            if (cmd_ok && op == OP_PAGE)  page_addr  <= din[PAGE_W-1:0];
            if (cmd_ok && op == OP_START) start_line <= din[LINE_W-1:0];
        end
    end

    // Contrast operand register, loaded only from the locked operand byte
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            contrast <= EC_RST;
        end else if (ec_load) begin
            contrast <= din[EC_W-1:0];
        end
    end

    // Line-reversal count and enable
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            nline_cnt <= '0;
            nline_on  <= 1'b0;
        end else if (cmd_ok && op == OP_NLINE) begin
            nline_cnt <= din[NL_W-1:0];
            nline_on  <= 1'b1;
        end else if (cmd_ok && op == OP_NLINE_OFF) begin
            nline_on  <= 1'b0;
        end
    end

    // Pin-reset-only registers: indicator, display enable, oscillator run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ind_on   <= 1'b0;
            ind_mode <= 2'b00;
            disp_on  <= 1'b0;
            osc_run  <= 1'b0;
        end else begin
            if (ind_load) begin
                ind_mode <= din[1:0];
                ind_on   <= 1'b1;
            end else if (cmd_ok && op == OP_IND_OFF) begin
                ind_on   <= 1'b0;
            end
            if (cmd_ok && op == OP_DISP) disp_on <= din[0];
            if (cmd_ok && op == OP_OSC && cfg_master && cfg_int_osc) osc_run <= 1'b1;
        end
    end

    // R1
    reset_val_chk: assert property (@(posedge clk)
        !rst_n |=> (contrast == EC_RST && col_addr == '0 && !disp_on && !osc_run && !rmw_on));

    // R3
    ec_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ec_load |=> ($stable(page_addr) && $stable(start_line) && $stable(disp_on)
                     && contrast == $past(din[EC_W-1:0])));

    // R6
    rmw_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rmw_on && bus_rd && !bus_wr) |=> $stable(col_addr));

    // R8
    osc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_run) |-> $past(cfg_master && cfg_int_osc));
endmodule

// File: tb/test_lcdc_cmd_top.sv
`timescale 1ns/1ps
module test_lcdc_cmd_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, is_data = 1'b0;
    logic [7:0] din = 8'h00;
    logic       cfg_master = 1'b1, cfg_int_osc = 1'b1;
    logic [7:0] col_addr;
    logic [3:0] page_addr, nline_cnt;
    logic [5:0] start_line, contrast;
    logic       nline_on, ind_on, disp_on, osc_run, rmw_on;
    logic [1:0] ind_mode;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lcdc_cmd_top i_lcdc_cmd_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .is_data(is_data), .din(din), .cfg_master(cfg_master),
        .cfg_int_osc(cfg_int_osc), .col_addr(col_addr), .page_addr(page_addr),
        .start_line(start_line), .contrast(contrast), .nline_cnt(nline_cnt),
        .nline_on(nline_on), .ind_on(ind_on), .ind_mode(ind_mode),
        .disp_on(disp_on), .osc_run(osc_run), .rmw_on(rmw_on)
    );

    function automatic logic [34:0] snap();
        return {col_addr, page_addr, start_line, contrast, nline_cnt,
                nline_on, ind_on, ind_mode, disp_on, osc_run, rmw_on};
    endfunction

    // Bytes with a meaning under R2..R9
    function automatic bit assigned(input logic [7:0] b);
        logic [3:0] h;
        h = b[7:4];
        if (h == 4'h0 || h == 4'h1 || h == 4'h3 || h == 4'hB) return 1;
        if (h >= 4'h4 && h <= 4'h7) return 1;
        return (b == 8'h8C || b == 8'h9B || b == 8'h9C || b == 8'h9D ||
                b == 8'h9E || b == 8'h9F || b == 8'hC0 || b == 8'hC1 ||
                b == 8'hC4 || b == 8'hC5);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic ctl(input logic [7:0] b);
        bus_wr = 1'b1; is_data = 1'b0; din = b;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic dwr();
        bus_wr = 1'b1; is_data = 1'b1; din = 8'h5A;
        @(negedge clk);
        bus_wr = 1'b0; is_data = 1'b0;
    endtask

    task automatic drd();
        bus_rd = 1'b1; is_data = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; is_data = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [34:0] ref_s;
        do_reset();
        // R1 reset state
        chk("R1", snap(), {8'd0, 4'd0, 6'd0, 6'b100000, 4'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0});

        // R2 page and start line sweeps, column nibbles, display
        for (int p = 0; p < 16; p++) begin
            ctl(8'hB0 | 8'(p));
            chk("R2 page", page_addr, p);
        end
        for (int s = 0; s < 64; s++) begin
            ctl(8'h40 | 8'(s));
            chk("R2 start", start_line, s);
        end
        ctl(8'h07); ctl(8'h15);
        chk("R2 col", col_addr, 8'h57);
        ctl(8'h9F); chk("R2 disp on", disp_on, 1);
        ctl(8'h9E); chk("R2 disp off", disp_on, 0);

        // R3 contrast lock sweep over every operand value
        for (int v = 0; v < 64; v++) begin
            ctl(8'h8C);
            ctl(8'(v) | 8'h80);
            chk("R3 contrast", contrast, v);
        end
        // R3 operand equal to opcodes is not decoded
        ctl(8'hB2); ctl(8'h8C); ctl(8'h9F);
        chk("R3 operand 9F", {contrast, disp_on}, {6'h1F, 1'b0});
        ctl(8'h8C); ctl(8'hB5);
        chk("R3 operand B5", {contrast, page_addr}, {6'h35, 4'h2});

        // R4 indicator lock
        ctl(8'h9D); ctl(8'hC5);
        chk("R4 ind load", {ind_on, ind_mode, col_addr}, {1'b1, 2'b01, 8'h57});
        ctl(8'h9D); ctl(8'h9E);
        chk("R4 ind mode", {ind_on, ind_mode}, {1'b1, 2'b10});
        ctl(8'h9C);
        chk("R4 ind off", {ind_on, ind_mode}, {1'b0, 2'b10});

        // R5 increment and saturation
        ctl(8'h00); ctl(8'h18);
        for (int k = 0; k < 6; k++) begin
            if (k[0]) drd(); else dwr();
            chk("R5 col inc", col_addr, (128 + k + 1 > 131) ? 131 : 128 + k + 1);
        end

        // R6 read-modify-write
        ctl(8'h0A); ctl(8'h10);
        ctl(8'hC0);
        chk("R6 enter", {rmw_on, col_addr}, {1'b1, 8'd10});
        repeat (3) drd();
        chk("R6 read hold", col_addr, 10);
        dwr(); dwr();
        chk("R6 write inc", col_addr, 12);
        ctl(8'h05); ctl(8'h13);
        chk("R6 col set blocked", col_addr, 12);
        ctl(8'hB3);
        chk("R6 page works", page_addr, 3);
        ctl(8'hC1);
        chk("R6 exit restore", {rmw_on, col_addr}, {1'b0, 8'd10});

        // R7 line reversal
        ctl(8'h3B);
        chk("R7 set", {nline_on, nline_cnt}, {1'b1, 4'hB});
        ctl(8'hC4);
        chk("R7 cancel", {nline_on, nline_cnt}, {1'b0, 4'hB});

        // R9 soft reset: set disp, ind, rmw first
        ctl(8'h9F); ctl(8'h9D); ctl(8'h03); ctl(8'h3C); ctl(8'hC0);
        ctl(8'hC5);
        chk("R9 soft reset", snap(), {8'd0, 4'd0, 6'd0, 6'b100000, 4'd0, 1'b0, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0});

        // R10 every unassigned byte and the no-op change nothing
        ctl(8'h1A); ctl(8'hB6); ctl(8'h55); ctl(8'h8C); ctl(8'h2A); ctl(8'h35);
        for (int b = 0; b < 256; b++) begin
            if (!assigned(8'(b))) begin
                ref_s = snap();
                ctl(8'(b));
                chk($sformatf("R10 byte %02h", b), snap(), ref_s);
            end
        end

        // R8 oscillator gating, all strap combinations
        for (int c = 0; c < 4; c++) begin
            do_reset();
            cfg_master = c[1]; cfg_int_osc = c[0];
            ctl(8'h9B);
            chk("R8 osc", osc_run, (c == 3) ? 1 : 0);
        end
        ctl(8'hC5);
        chk("R8 osc kept by R9", osc_run, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule